// File: doc/BRIEF.md
# Calendar Alarm Compare Unit

This block holds four alarm compare values (month, day, hour, minute) and checks each against the matching live count from an external time-of-day counter chain. Each field has a compare enable and a sticky match flag. Software sees all enables and flags in one 8-bit control/status byte on a small CPU register bus. The bus has an address, a write strobe, a read-modify-write indication and combinational read data. The compare values sit at their own addresses.

One interrupt request output is driven in one of two modes, chosen by a single mode input. In the per-field mode, any flag whose field is enabled raises the request. In the combined mode, the request is raised only when every enabled field matches in the same cycle, and it stays high until software has cleared the enabled flags. A flag is set only on the first cycle of a match, so a match that lasts does not set the flag again once it has been cleared. A hardware set beats a software clear that lands in the same cycle.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset, every flag, every enable and every compare register is 0, and `irq` is 0.
- R2: Address 0 is the control/status byte. Its bits are: bit 7 month flag, bit 6 day flag, bit 5 hour flag, bit 4 minute flag, bit 3 month enable, bit 2 day enable, bit 1 hour enable, bit 0 minute enable. The compare registers sit at address 1 (month, 4 bits), 2 (day, 5 bits), 3 (hour, 5 bits) and 4 (minute, 6 bits). A write keeps only the low bits that fit the register, and a read returns the value zero-extended. Any other address reads 0. A written value takes effect at the next clock edge.
- R3: While a field is enabled, a cycle in which its compare register equals its count, after a cycle in which it did not match, sets that field's flag at the end of that cycle.
- R4: A field whose enable is 0 never sets its flag.
- R5: A write to address 0 loads bits 3..0 into the enables. For each flag, a 0 in its bit clears the flag and a 1 leaves it unchanged.
- R6: A match that continues without a break does not set the flag again after software has cleared it.
- R7: While `bus_rmw` is 1 and the address is 0, bits 7..4 of `bus_rdata` read as 1 and bits 3..0 show the enables. With `bus_rmw` at 0, the real flags are read.
- R8: With `alarm_all_mode` at 0, `irq` is 1 exactly when some flag is 1 and its enable is 1.
- R9: With `alarm_all_mode` at 1, `irq` rises at the end of the first cycle in which at least one field is enabled and every enabled field matches. A partial match leaves `irq` at 0.
- R10: In combined mode, `irq` stays 1 until a clock edge after which no enabled flag is set, and it falls at that edge. A match that continues does not raise it again.
- R11: When a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rmw | input | 1 | Current read belongs to a read-modify-write access |
| bus_rdata | output | 8 | Combinational read data |
| cnt_month | input | 4 | Live month count |
| cnt_day | input | 5 | Live day count |
| cnt_hour | input | 5 | Live hour count |
| cnt_min | input | 6 | Live minute count |
| alarm_all_mode | input | 1 | 0: per-field interrupt, 1: combined interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag set and a software clear landing on the same edge. To get there, the minute count is first moved off its compare value for one edge, so the edge detector re-arms. Then the bench restores the count in the same cycle as a control write that carries a 0 in the minute flag bit. The combined mode needs fields that match at different times: the bench holds one field off by one while the others already match, then closes the gap on the hour count. After that it clears the flags one at a time, to show that the request is held and then drops. A phase of random bus traffic over small count ranges follows, checked on every cycle against a behavioural model.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   localparam int NUM_FIELDS = 4;
   localparam int DATA_W     = 8;
   // field index: also the enable bit, flag bit is FLAG_LSB + index
   localparam int FLD_MIN    = 0;
   localparam int FLD_HOUR   = 1;
   localparam int FLD_DAY    = 2;
   localparam int FLD_MON    = 3;
   localparam int FLAG_LSB   = NUM_FIELDS;

   typedef logic [NUM_FIELDS-1:0] fld_vec_t;
endpackage

// File: rtl/cal_alarm_field.sv
module cal_alarm_field #(
   parameter int W        = 6,
   parameter bit EDGE_SET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmp_wr,
   input  logic [W-1:0] cmp_wdata,
   input  logic [W-1:0] cnt,
   input  logic         enable,
   input  logic         ctl_wr,
   input  logic         keep_bit,
   output logic [W-1:0] cmp_q,
   output logic         match,
   output logic         rise,
   output logic         flag_q,
   output logic         flag_d
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (cmp_wr) cmp_q <= cmp_wdata;
   end

   assign match = enable && (cmp_q == cnt);

   if (EDGE_SET) begin : g_edge
      logic match_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) match_q <= 1'b0;
         else        match_q <= match;
      end
      assign rise = match & ~match_q;
   end else begin : g_level
      assign rise = match;
   end

   // hardware set has priority over a software clear
   assign flag_d = rise | (flag_q & ~(ctl_wr & ~keep_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end
endmodule

// File: rtl/cal_alarm_regif.sv
module cal_alarm_regif
   import cal_alarm_pkg::*;
#(
   parameter int                             ADDR_W   = 3,
   parameter int                             MAX_W    = 6,
   parameter int                             CTL_ADDR = 0,
   parameter logic [NUM_FIELDS*ADDR_W-1:0]   FADDR_PK = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_wr,
   input  logic                        bus_rmw,
   input  fld_vec_t                    en_wdata,
   input  fld_vec_t                    flag_q,
   input  logic [NUM_FIELDS*MAX_W-1:0] cmp_pk,
   output logic                        ctl_wr,
   output fld_vec_t                    cmp_wr,
   output fld_vec_t                    en_q,
   output fld_vec_t                    en_d,
   output logic [DATA_W-1:0]           bus_rdata
);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

   assign ctl_wr = bus_wr && (bus_addr == CTL_A);

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
      assign cmp_wr[i] = bus_wr && (bus_addr == FADDR_PK[i*ADDR_W +: ADDR_W]);
   end

   assign en_d = ctl_wr ? en_wdata : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTL_A)
         bus_rdata = {(bus_rmw ? {NUM_FIELDS{1'b1}} : flag_q), en_q};
      for (int i = 0; i < NUM_FIELDS; i++)
         if (bus_addr == FADDR_PK[i*ADDR_W +: ADDR_W])
            bus_rdata = DATA_W'(cmp_pk[i*MAX_W +: MAX_W]);
   end
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
   import cal_alarm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     all_mode,
   input  fld_vec_t en_q,
   input  fld_vec_t en_d,
   input  fld_vec_t match,
   input  fld_vec_t flag_q,
   input  fld_vec_t flag_d,
   output logic     irq
);
   logic all_match, all_q, all_rise, combo_q, combo_d;

   assign all_match = (|en_q) && (&(match | ~en_q));
   assign all_rise  = all_match & ~all_q;
   assign combo_d   = all_rise | (combo_q & (|(flag_d & en_d)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         all_q   <= 1'b0;
         combo_q <= 1'b0;
      end else begin
         all_q   <= all_match;
         combo_q <= combo_d;
      end
   end

   assign irq = all_mode ? combo_q : (|(flag_q & en_q));
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
   import cal_alarm_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int MON_W     = 4,
   parameter int DAY_W     = 5,
   parameter int HOUR_W    = 5,
   parameter int MIN_W     = 6,
   parameter int CTL_ADDR  = 0,
   parameter int MON_ADDR  = 1,
   parameter int DAY_ADDR  = 2,
   parameter int HOUR_ADDR = 3,
   parameter int MIN_ADDR  = 4,
   parameter bit EDGE_SET  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_rmw,
   output logic [7:0]        bus_rdata,
   input  logic [MON_W-1:0]  cnt_month,
   input  logic [DAY_W-1:0]  cnt_day,
   input  logic [HOUR_W-1:0] cnt_hour,
   input  logic [MIN_W-1:0]  cnt_min,
   input  logic              alarm_all_mode,
   output logic              irq
);
   localparam int MW_A  = (MON_W > DAY_W) ? MON_W : DAY_W;
   localparam int MW_B  = (HOUR_W > MIN_W) ? HOUR_W : MIN_W;
   localparam int MAX_W = (MW_A > MW_B) ? MW_A : MW_B;
   localparam int FW [NUM_FIELDS] = '{MIN_W, HOUR_W, DAY_W, MON_W};
   localparam logic [NUM_FIELDS*ADDR_W-1:0] FADDR_PK =
      {ADDR_W'(MON_ADDR), ADDR_W'(DAY_ADDR), ADDR_W'(HOUR_ADDR), ADDR_W'(MIN_ADDR)};

   if (MAX_W > DATA_W || MON_W < 1 || DAY_W < 1 || HOUR_W < 1 || MIN_W < 1) begin : g_bad_width
      $error("field widths must lie between 1 and the data width");
   end
   if (CTL_ADDR >= (1 << ADDR_W) || MON_ADDR >= (1 << ADDR_W) || DAY_ADDR >= (1 << ADDR_W)
       || HOUR_ADDR >= (1 << ADDR_W) || MIN_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("register address outside the address space");
   end
   if (CTL_ADDR == MON_ADDR || CTL_ADDR == DAY_ADDR || CTL_ADDR == HOUR_ADDR
       || CTL_ADDR == MIN_ADDR || MON_ADDR == DAY_ADDR || MON_ADDR == HOUR_ADDR
       || MON_ADDR == MIN_ADDR || DAY_ADDR == HOUR_ADDR || DAY_ADDR == MIN_ADDR
       || HOUR_ADDR == MIN_ADDR) begin : g_bad_map
      $error("register addresses must be distinct");
   end

   fld_vec_t                    en_q, en_d, flag_q, flag_d, match_v, rise_v, cmp_wr;
   logic                        ctl_wr;
   logic [NUM_FIELDS*MAX_W-1:0] cmp_pk;

   cal_alarm_regif #(
      .ADDR_W  (ADDR_W),
      .MAX_W   (MAX_W),
      .CTL_ADDR(CTL_ADDR),
      .FADDR_PK(FADDR_PK)
   ) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_rmw  (bus_rmw),
      .en_wdata (bus_wdata[NUM_FIELDS-1:0]),
      .flag_q   (flag_q),
      .cmp_pk   (cmp_pk),
      .ctl_wr   (ctl_wr),
      .cmp_wr   (cmp_wr),
      .en_q     (en_q),
      .en_d     (en_d),
      .bus_rdata(bus_rdata)
   );

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
      localparam int W = FW[i];
      logic [W-1:0] cnt_w, cmp_w;

      if (i == FLD_MIN) begin : g_cmin
         assign cnt_w = cnt_min;
      end else if (i == FLD_HOUR) begin : g_chour
         assign cnt_w = cnt_hour;
      end else if (i == FLD_DAY) begin : g_cday
         assign cnt_w = cnt_day;
      end else begin : g_cmon
         assign cnt_w = cnt_month;
      end

      cal_alarm_field #(
         .W       (W),
         .EDGE_SET(EDGE_SET)
      ) u_fld (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmp_wr   (cmp_wr[i]),
         .cmp_wdata(bus_wdata[W-1:0]),
         .cnt      (cnt_w),
         .enable   (en_q[i]),
         .ctl_wr   (ctl_wr),
         .keep_bit (bus_wdata[FLAG_LSB+i]),
         .cmp_q    (cmp_w),
         .match    (match_v[i]),
         .rise     (rise_v[i]),
         .flag_q   (flag_q[i]),
         .flag_d   (flag_d[i])
      );

      assign cmp_pk[i*MAX_W +: MAX_W] = MAX_W'(cmp_w);
   end

   cal_alarm_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .all_mode(alarm_all_mode),
      .en_q    (en_q),
      .en_d    (en_d),
      .match   (match_v),
      .flag_q  (flag_q),
      .flag_d  (flag_d),
      .irq     (irq)
   );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
   parameter int ADDR_W   = 3,
   parameter int CTL_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [7:0]        bus_wdata,
   input logic              bus_rmw,
   input logic [7:0]        bus_rdata,
   input logic              alarm_all_mode,
   input logic              irq,
   input logic [3:0]        en_q,
   input logic [3:0]        flag_q,
   input logic [3:0]        rise_v
);
   logic ctl_hit;
   assign ctl_hit = (bus_addr == ADDR_W'(CTL_ADDR));

   assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_v != 4'h0) |=> ((flag_q & $past(rise_v)) == $past(rise_v)));

   assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((~en_q & ~flag_q) != 4'h0) |=> ((flag_q & $past(~en_q & ~flag_q)) == 4'h0));

   assert_w0_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctl_hit) |=> ((flag_q & ~$past(bus_wdata[7:4]) & ~$past(rise_v)) == 4'h0));

   assert_w1_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctl_hit) |=>
         ((flag_q & $past(flag_q & bus_wdata[7:4])) == $past(flag_q & bus_wdata[7:4])));

   assert_en_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctl_hit) |=> (en_q == $past(bus_wdata[3:0])));

   assert_no_reflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q != 4'hF) |=> ((flag_q & $past(~flag_q & ~rise_v)) == 4'h0));

   assert_rmw_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_hit && bus_rmw) |-> (bus_rdata[7:4] == 4'hF));

   assert_any_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_all_mode) |-> (irq == (|(flag_q & en_q))));
endmodule

bind cal_alarm_cmp cal_alarm_chk #(
   .ADDR_W  (ADDR_W),
   .CTL_ADDR(CTL_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_addr      (bus_addr),
   .bus_wr        (bus_wr),
   .bus_wdata     (bus_wdata),
   .bus_rmw       (bus_rmw),
   .bus_rdata     (bus_rdata),
   .alarm_all_mode(alarm_all_mode),
   .irq           (irq),
   .en_q          (en_q),
   .flag_q        (flag_q),
   .rise_v        (rise_v)
);

// File: tb/cal_alarm_cmp_bench.sv
`timescale 1ns/1ps
module cal_alarm_cmp_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rmw = 1'b0;
   logic [7:0] bus_rdata;
   logic [3:0] cnt_month = '0;
   logic [4:0] cnt_day = '0;
   logic [4:0] cnt_hour = '0;
   logic [5:0] cnt_min = '0;
   logic       alarm_all_mode = 1'b0;
   logic       irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cal_alarm_cmp u_cal_alarm_cmp (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
      .cnt_month(cnt_month), .cnt_day(cnt_day), .cnt_hour(cnt_hour),
      .cnt_min(cnt_min), .alarm_all_mode(alarm_all_mode), .irq(irq)
   );

   // behavioural model, index 0 minute, 1 hour, 2 day, 3 month
   int m_en[4], m_flag[4], m_cmp[4], m_prev[4];
   int m_allprev, m_combo;
   int fmask[4] = '{63, 31, 31, 15};

   function automatic int cnt_of(int i);
      case (i)
         0: return int'(cnt_min);
         1: return int'(cnt_hour);
         2: return int'(cnt_day);
         default: return int'(cnt_month);
      endcase
   endfunction

   always @(posedge clk) begin : model
      int mt[4], nx[4], en_nx[4];
      int allm, anyen, hold, ctlw;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_flag[i] = 0; m_cmp[i] = 0; m_prev[i] = 0;
         end
         m_allprev = 0; m_combo = 0;
      end else begin
         ctlw = (bus_wr && bus_addr == 3'd0) ? 1 : 0;
         anyen = 0; allm = 1; hold = 0;
         for (int i = 0; i < 4; i++) begin
            mt[i] = (m_en[i] != 0 && m_cmp[i] == cnt_of(i)) ? 1 : 0;
            if (mt[i] != 0 && m_prev[i] == 0) nx[i] = 1;
            else if (ctlw != 0 && bus_wdata[4+i] == 1'b0) nx[i] = 0;
            else nx[i] = m_flag[i];
            en_nx[i] = (ctlw != 0) ? int'(bus_wdata[i]) : m_en[i];
            if (m_en[i] != 0) anyen = 1;
            if (m_en[i] != 0 && mt[i] == 0) allm = 0;
            if (nx[i] != 0 && en_nx[i] != 0) hold = 1;
         end
         if (anyen == 0) allm = 0;
         m_combo = ((allm != 0 && m_allprev == 0) || (m_combo != 0 && hold != 0)) ? 1 : 0;
         m_allprev = allm;
         for (int i = 0; i < 4; i++) begin
            m_prev[i] = mt[i];
            m_flag[i] = nx[i];
            m_en[i] = en_nx[i];
         end
         if (bus_wr && bus_addr >= 3'd1 && bus_addr <= 3'd4)
            m_cmp[4 - int'(bus_addr)] = int'(bus_wdata) & fmask[4 - int'(bus_addr)];
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic int model_rdata();
      int v;
      v = 0;
      if (bus_addr == 3'd0) begin
         for (int i = 0; i < 4; i++) begin
            if (bus_rmw || m_flag[i] != 0) v |= (1 << (4 + i));
            if (m_en[i] != 0) v |= (1 << i);
         end
      end else if (bus_addr <= 3'd4) v = m_cmp[4 - int'(bus_addr)];
      return v;
   endfunction

   function automatic int model_irq();
      int v;
      v = 0;
      if (alarm_all_mode) v = m_combo;
      else for (int i = 0; i < 4; i++) if (m_flag[i] != 0 && m_en[i] != 0) v = 1;
      return v;
   endfunction

   // compare against the model every cycle, away from the clock edge
   always begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
         chk(alarm_all_mode ? "R9 irq vs model" : "R8 irq vs model", int'(irq), model_irq());
         chk((bus_addr == 3'd0 && bus_rmw) ? "R7 rdata vs model" : "R2 rdata vs model",
             int'(bus_rdata), model_rdata());
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rmw = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(logic [2:0] a, logic rmw, int exp, string tag);
      bus_addr = a; bus_rmw = rmw;
      #1;
      chk(tag, int'(bus_rdata), exp);
      @(negedge clk);
      bus_rmw = 1'b0;
   endtask

   task automatic irq_chk(int exp, string tag);
      #1;
      chk(tag, int'(irq), exp);
      @(negedge clk);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      finish_up();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1: reset state
      rd_chk(3'd0, 1'b0, 8'h00, "R1 control byte after reset");
      rd_chk(3'd4, 1'b0, 8'h00, "R1 minute compare after reset");
      irq_chk(0, "R1 irq after reset");

      // R2: compare registers, truncation, unmapped
      wr(3'd1, 8'd5);
      rd_chk(3'd1, 1'b0, 8'h05, "R2 month compare readback");
      wr(3'd4, 8'hFF);
      rd_chk(3'd4, 1'b0, 8'h3F, "R2 minute compare truncated");
      rd_chk(3'd7, 1'b0, 8'h00, "R2 unmapped address");

      // R4: disabled field with matching count
      cnt_month = 4'd5;
      tick(2);
      rd_chk(3'd0, 1'b0, 8'h00, "R4 disabled month never flags");

      // R3 and R8: enable month while matching
      wr(3'd0, 8'h08);
      tick(1);
      rd_chk(3'd0, 1'b0, 8'h88, "R3 month flag set");
      irq_chk(1, "R8 irq on enabled flag");

      // R5 clear and R6 persistent match
      wr(3'd0, 8'h08);
      rd_chk(3'd0, 1'b0, 8'h08, "R5 write 0 clears flag");
      tick(3);
      rd_chk(3'd0, 1'b0, 8'h08, "R6 persistent match does not reflag");
      irq_chk(0, "R6 irq stays low");

      // minute alarm, R5 keep
      cnt_min = 6'd10;
      wr(3'd4, 8'd10);
      wr(3'd0, 8'h09);
      tick(1);
      rd_chk(3'd0, 1'b0, 8'h19, "R3 minute flag set");
      wr(3'd0, 8'hF9);
      rd_chk(3'd0, 1'b0, 8'h19, "R5 write 1 keeps flag");

      // R7: read-modify-write view
      rd_chk(3'd0, 1'b1, 8'hF9, "R7 rmw reads flags as 1");
      rd_chk(3'd0, 1'b0, 8'h19, "R7 plain read shows real flags");

      // R11: set and clear in the same cycle
      wr(3'd0, 8'h09);
      rd_chk(3'd0, 1'b0, 8'h09, "R5 minute flag cleared");
      cnt_min = 6'd11;
      tick(1);
      cnt_min = 6'd10;
      wr(3'd0, 8'h09);
      rd_chk(3'd0, 1'b0, 8'h19, "R11 set wins over clear");

      // R9: combined mode
      wr(3'd0, 8'h00);
      cnt_day = 5'd3; cnt_hour = 5'd7;
      wr(3'd2, 8'd3);
      wr(3'd3, 8'd8);
      alarm_all_mode = 1'b1;
      wr(3'd0, 8'h0F);
      tick(1);
      rd_chk(3'd0, 1'b0, 8'hDF, "R9 partial match flags");
      irq_chk(0, "R9 partial match keeps irq low");
      cnt_hour = 5'd8;
      tick(1);
      irq_chk(1, "R9 all enabled fields match");

      // R10: held until enabled flags cleared
      wr(3'd0, 8'h7F);
      irq_chk(1, "R10 irq held with flags left");
      wr(3'd0, 8'h0F);
      irq_chk(0, "R10 irq drops when flags cleared");
      tick(3);
      irq_chk(0, "R10 persistent match no re-raise");
      alarm_all_mode = 1'b0;
      irq_chk(0, "R8 no flags no irq");

      // random traffic against the model
      for (int k = 0; k < 800; k++) begin
         bus_wr    = ($urandom_range(0, 3) == 0);
         bus_addr  = 3'($urandom_range(0, 5));
         bus_wdata = 8'($urandom_range(0, 255));
         if (bus_wdata[7:4] != 4'h0 && $urandom_range(0, 1) == 1) bus_wdata[7:4] = 4'hF;
         if (bus_addr != 3'd0) bus_wdata = bus_wdata & 8'h03;
         bus_rmw   = ($urandom_range(0, 1) == 1);
         cnt_month = 4'($urandom_range(0, 3));
         cnt_day   = 5'($urandom_range(0, 3));
         cnt_hour  = 5'($urandom_range(0, 3));
         cnt_min   = 6'($urandom_range(0, 3));
         if ($urandom_range(0, 31) == 0) alarm_all_mode = ~alarm_all_mode;
         @(negedge clk);
      end
      bus_wr = 1'b0;
      tick(2);
      finish_up();
   end
endmodule